// File: doc/BRIEF.md
# Byte-Coded SPI Master Sequencer

This block is a half-duplex SPI master whose transfers are driven by a small program rather than by the host feeding bytes one at a time. The host loads a 64-bit program word that holds eight one-byte opcodes. Writing that word starts execution. The opcodes select or release a chip select, shift bytes out of a 64-bit transmit register, shift bytes into a 64-bit receive register, copy received data back for transmission, and branch backwards while a loop count remains.

While the program runs, the host keeps the data registers flowing through their full flags. Refilling the transmit register releases a stalled shift-out. Draining the receive register releases a stalled shift-in. A status word reports the two full flags, three error flags and a one-hot sequencer state code. SCK idles low, and data is captured on its rising edge (SPI mode 0). The rate comes from a divider held in a clock configuration register.

Top module: `spi_opseq`

## Requirements
- R1: After reset the status word reads 0x0001_0000_0000_0000 (state code 0x01 in bits 55:48, all flags clear), every chip select is high, SCK is low, and the clock configuration reads divider 19 in bits 63:52 with all other bits zero.
- R2: A program write while idle (register 0) starts execution at slot 0, in bits 63:56, and proceeds toward the least significant byte. Opcode 0x00 stops execution. After slot 7 the run also ends. The state then returns to idle. A program write while a run is active is ignored.
- R3: Opcode 0x1N with N of 1 or more drives chip select N-1 low and all others high. With N = 0 it drives every chip select high. Chip selects are active low.
- R4: Opcode 0x3N sends N bytes (N = 0 sends nothing, N above 8 sends 8). The bytes come from the transmit register (register 1), most significant bit first, and change while SCK is low. The opcode stalls until transmit-full (status bit 59) is set, and it clears that flag when the bytes are out.
- R5: Opcode 0x4N captures N bytes from MISO on rising SCK edges. They go into the low-order bytes of the receive register (register 2), whose other bits read zero, and receive-full (status bit 63) is then set. A shift-in stalls while receive-full is set. Reading register 2 while full clears the flag.
- R6: Opcode 0xEN jumps to slot N (low three bits) and decrements the loop counter while the counter is nonzero. Otherwise it falls through. The counter is loaded at program start from bits 39:32 of the loop configuration (register 3). When bit 11 of that register is set, it is reloaded on each fall-through.
- R7: With loop configuration bit 10 set, the first shift-in of a run waits, with SCK idle, for one host write to the transmit register. It then consumes that write, clearing transmit-full, before clocking.
- R8: Opcode 0xC0 moves the receive register into the transmit register, sets transmit-full and clears receive-full.
- R9: A transmit register write while transmit-full is set sets the transmit overrun flag (status bit 58) and the written data is discarded.
- R10: A receive register read while receive-full is clear sets the receive underrun flag (status bit 61). Any write to the receive register sets the receive overrun flag (status bit 62).
- R11: A status write (register 5) clears each error flag whose bit in the written value is zero, so writing zero clears all three.
- R12: Each SCK phase, high or low, lasts divider+1 system clocks, with the divider taken from clock configuration (register 4) bits 63:52.
- R13: Status bits 55:48 hold a one-hot state code: 0x01 idle, 0x02 executing or stalled, 0x04 shifting out, 0x08 shifting in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe (has side effects on register 2) |
| host_addr | input | 3 | Register index 0 to 5 |
| host_wdata | input | 64 | Write data |
| host_rdata | output | 64 | Read data for host_addr, combinational |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench targets the counted branch with and without reload. A design that mishandled either would send the wrong number of bytes, or stall forever waiting for a refill that never comes.

It holds the sequencer against a full receive register and against an unprimed implicit-mode shift-in. In both cases it checks that SCK never toggles, since a missing stall would overwrite unread data or clock early. It sends a program write into a stalled run to show that the running program is not replaced.

Further targets are:
- slot 7 as the last executed slot, and opcode order;
- the overrun and underrun flags, including selective clearing;
- the state code and the SCK high time at a non-default divider.

// File: rtl/spi_opseq_pkg.sv
package spi_opseq_pkg;

  localparam int DW     = 64;
  localparam int DIV_W  = 12;
  localparam int BITS_W = 7;

  localparam logic [2:0] ADDR_PROG = 3'd0;
  localparam logic [2:0] ADDR_TX   = 3'd1;
  localparam logic [2:0] ADDR_RX   = 3'd2;
  localparam logic [2:0] ADDR_LOOP = 3'd3;
  localparam logic [2:0] ADDR_CLK  = 3'd4;
  localparam logic [2:0] ADDR_STAT = 3'd5;

  localparam int CFG_IMPLICIT_BIT = 10;
  localparam int CFG_RELOAD_BIT   = 11;
  localparam int LOOP_LO          = 32;
  localparam int DIV_LO           = 52;

  localparam int ST_RX_FULL = 63;
  localparam int ST_RX_OVR  = 62;
  localparam int ST_RX_UND  = 61;
  localparam int ST_TX_FULL = 59;
  localparam int ST_TX_OVR  = 58;
  localparam int ST_CODE_LO = 48;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_SHIFT} seq_state_e;

  typedef enum logic [2:0] {
    OPC_STOP, OPC_SEL, OPC_OUT, OPC_IN, OPC_COPY, OPC_BRANCH, OPC_NOP
  } op_cls_e;

  // Opcode byte held in a slot; slot 0 is the most significant byte.
  function automatic logic [7:0] slot_byte(input logic [DW-1:0] prog,
                                           input logic [2:0] idx);
    logic [5:0] lsb;
    lsb = {3'd7 - idx, 3'b000};
    return prog[lsb +: 8];
  endfunction

  // Number of serial bits for a byte-count nibble.
  function automatic logic [BITS_W-1:0] shift_bits(input logic [3:0] n);
    if (n == 4'd0)      return '0;
    else if (n > 4'd8)  return 7'd64;
    else                return {n, 3'b000};
  endfunction

  function automatic logic [7:0] state_code(input seq_state_e st,
                                            input logic dir_in);
    case (st)
      ST_IDLE: return 8'h01;
      ST_EXEC: return 8'h02;
      default: return dir_in ? 8'h08 : 8'h04;
    endcase
  endfunction

  function automatic logic [DW-1:0] pack_status(input logic rx_full,
      input logic rx_ovr, input logic rx_und, input logic tx_full,
      input logic tx_ovr, input logic [7:0] code);
    logic [DW-1:0] s;
    s = '0;
    s[ST_RX_FULL] = rx_full;
    s[ST_RX_OVR]  = rx_ovr;
    s[ST_RX_UND]  = rx_und;
    s[ST_TX_FULL] = tx_full;
    s[ST_TX_OVR]  = tx_ovr;
    s[ST_CODE_LO +: 8] = code;
    return s;
  endfunction

endpackage

// File: rtl/spi_opseq_decode.sv
module spi_opseq_decode
  import spi_opseq_pkg::*;
(
  input  logic [7:0] op,
  output op_cls_e    cls,
  output logic [3:0] nib
);
  assign nib = op[3:0];

  always_comb begin
    case (op[7:4])
      4'h0:    cls = (op[3:0] == 4'h0) ? OPC_STOP : OPC_NOP;
      4'h1:    cls = OPC_SEL;
      4'h3:    cls = OPC_OUT;
      4'h4:    cls = OPC_IN;
      4'hC:    cls = (op[3:0] == 4'h0) ? OPC_COPY : OPC_NOP;
      4'hE:    cls = OPC_BRANCH;
      default: cls = OPC_NOP;
    endcase
  end
endmodule

// File: rtl/spi_opseq_cs.sv
module spi_opseq_cs #(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_fire,
  input  logic [3:0]        sel_nib,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cs_n[i] <= 1'b1;
      else if (sel_fire) cs_n[i] <= (sel_nib != 4'(i + 1));
    end
  end

  // R3: never more than one chip select low
  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
endmodule

// File: rtl/spi_opseq_shifter.sv
module spi_opseq_shifter
  import spi_opseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_out,
  input  logic [BITS_W-1:0] nbits,
  input  logic [DW-1:0]     load_word,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     cap_word
);
  logic [DW-1:0]     sh_q;
  logic [BITS_W-1:0] left_q;
  logic [DIV_W-1:0]  hcnt_q;
  logic              out_q;

  logic phase_end, rise_evt, fall_evt;
  assign phase_end = busy && (hcnt_q == '0);
  assign rise_evt  = phase_end && !sck;
  assign fall_evt  = phase_end && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; cap_word <= '0; left_q <= '0; hcnt_q <= '0;
      sck <= 1'b0; busy <= 1'b0; done <= 1'b0; out_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy     <= 1'b1;
        sh_q     <= load_word;
        cap_word <= '0;
        left_q   <= nbits;
        hcnt_q   <= div;
        sck      <= 1'b0;
        out_q    <= is_out;
      end else if (busy) begin
        if (!phase_end) hcnt_q <= hcnt_q - 1'b1;
        else            hcnt_q <= div;
        if (rise_evt) begin
          sck      <= 1'b1;
          cap_word <= {cap_word[DW-2:0], miso};
        end
        if (fall_evt) begin
          sck    <= 1'b0;
          sh_q   <= {sh_q[DW-2:0], 1'b0};
          left_q <= left_q - 1'b1;
          if (left_q == 7'd1) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  assign mosi = busy && out_q && sh_q[DW-1];

  // R12: SCK only toggles during a shift
  a_r12_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R12: a shift finishes on a falling SCK edge
  a_r12_done_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(sck));
endmodule

// File: rtl/spi_opseq.sv
module spi_opseq
  import spi_opseq_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int DIV_RESET = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [2:0]        host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam logic [DW-1:0] CLK_CFG_RST = {DIV_W'(DIV_RESET), {DIV_LO{1'b0}}};

  logic [DW-1:0] prog_q, tx_q, rx_q, loop_cfg_q, clk_cfg_q;
  logic          tx_full_q, rx_full_q, tx_ovr_q, rx_und_q, rx_ovr_q;
  seq_state_e    state_q;
  logic [2:0]    pc_q;
  logic [7:0]    loop_cnt_q;
  logic          primed_q, dir_in_q;

  // host events
  logic wr_prog, wr_tx, wr_rx, wr_loop, wr_clk, wr_stat, rd_rx;
  assign wr_prog = host_we && host_addr == ADDR_PROG;
  assign wr_tx   = host_we && host_addr == ADDR_TX;
  assign wr_rx   = host_we && host_addr == ADDR_RX;
  assign wr_loop = host_we && host_addr == ADDR_LOOP;
  assign wr_clk  = host_we && host_addr == ADDR_CLK;
  assign wr_stat = host_we && host_addr == ADDR_STAT;
  assign rd_rx   = host_re && host_addr == ADDR_RX;

  // decode of the current slot
  op_cls_e           op_cls;
  logic [3:0]        op_nib;
  logic [BITS_W-1:0] op_bits;
  spi_opseq_decode u_dec (.op(slot_byte(prog_q, pc_q)), .cls(op_cls), .nib(op_nib));
  assign op_bits = shift_bits(op_nib);

  logic implicit_en, reload_en;
  assign implicit_en = loop_cfg_q[CFG_IMPLICIT_BIT];
  assign reload_en   = loop_cfg_q[CFG_RELOAD_BIT];

  // sequencer events
  logic step, halt, sel_fire, shift_start, prime_take, copy_fire;
  logic take_branch, branch_fall, out_done, rx_load, end_run;
  logic shift_done, sh_busy;
  logic [DW-1:0] cap_word;

  always_comb begin
    step = 1'b0; halt = 1'b0; sel_fire = 1'b0; shift_start = 1'b0;
    prime_take = 1'b0; copy_fire = 1'b0; take_branch = 1'b0;
    branch_fall = 1'b0; out_done = 1'b0; rx_load = 1'b0;
    if (state_q == ST_EXEC) begin
      case (op_cls)
        OPC_STOP: halt = 1'b1;
        OPC_SEL: begin sel_fire = 1'b1; step = 1'b1; end
        OPC_OUT: begin
          if (op_bits == '0)  step = 1'b1;
          else if (tx_full_q) shift_start = 1'b1;
        end
        OPC_IN: begin
          if (op_bits == '0) step = 1'b1;
          else if (implicit_en && !primed_q) prime_take = tx_full_q;
          else if (!rx_full_q) shift_start = 1'b1;
        end
        OPC_COPY: begin copy_fire = 1'b1; step = 1'b1; end
        OPC_BRANCH: begin
          if (loop_cnt_q != 8'd0) take_branch = 1'b1;
          else begin branch_fall = 1'b1; step = 1'b1; end
        end
        default: step = 1'b1;
      endcase
    end else if (state_q == ST_SHIFT && shift_done) begin
      step     = 1'b1;
      out_done = !dir_in_q;
      rx_load  = dir_in_q;
    end
    end_run = halt || (step && pc_q == 3'd7);
  end

  // sequencer state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; pc_q <= '0; loop_cnt_q <= '0;
      primed_q <= 1'b0; dir_in_q <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (wr_prog) begin
        state_q    <= ST_EXEC;
        pc_q       <= '0;
        loop_cnt_q <= loop_cfg_q[LOOP_LO +: 8];
        primed_q   <= 1'b0;
      end
    end else begin
      if (end_run)          state_q <= ST_IDLE;
      else if (shift_start) state_q <= ST_SHIFT;
      else if (step)        state_q <= ST_EXEC;
      if (shift_start) dir_in_q <= (op_cls == OPC_IN);
      if (prime_take)  primed_q <= 1'b1;
      if (step && pc_q != 3'd7) pc_q <= pc_q + 3'd1;
      if (take_branch) begin
        pc_q       <= op_nib[2:0];
        loop_cnt_q <= loop_cnt_q - 8'd1;
      end
      if (branch_fall && reload_en) loop_cnt_q <= loop_cfg_q[LOOP_LO +: 8];
    end
  end

  // data registers and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0; tx_q <= '0; rx_q <= '0; loop_cfg_q <= '0;
      clk_cfg_q <= CLK_CFG_RST;
      tx_full_q <= 1'b0; rx_full_q <= 1'b0;
      tx_ovr_q <= 1'b0; rx_und_q <= 1'b0; rx_ovr_q <= 1'b0;
    end else begin
      if (wr_prog && state_q == ST_IDLE) prog_q <= host_wdata;
      if (wr_loop) loop_cfg_q <= host_wdata;
      if (wr_clk)  clk_cfg_q  <= host_wdata;
      // transmit side
      if (out_done || prime_take) tx_full_q <= 1'b0;
      if (copy_fire) begin
        tx_q      <= rx_q;
        tx_full_q <= 1'b1;
      end
      if (wr_tx) begin
        if (tx_full_q) tx_ovr_q <= 1'b1;
        else begin
          tx_q      <= host_wdata;
          tx_full_q <= 1'b1;
        end
      end
      // receive side
      if (copy_fire) rx_full_q <= 1'b0;
      if (rd_rx) begin
        if (rx_full_q) rx_full_q <= 1'b0;
        else           rx_und_q  <= 1'b1;
      end
      if (rx_load) begin
        rx_q      <= cap_word;
        rx_full_q <= 1'b1;
      end
      if (wr_rx) rx_ovr_q <= 1'b1;
      if (wr_stat) begin
        tx_ovr_q <= tx_ovr_q & host_wdata[ST_TX_OVR];
        rx_und_q <= rx_und_q & host_wdata[ST_RX_UND];
        rx_ovr_q <= rx_ovr_q & host_wdata[ST_RX_OVR];
      end
    end
  end

  spi_opseq_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(shift_start), .is_out(op_cls == OPC_OUT),
    .nbits(op_bits), .load_word(tx_q), .div(clk_cfg_q[DIV_LO +: DIV_W]),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .busy(sh_busy),
    .done(shift_done), .cap_word(cap_word)
  );

  spi_opseq_cs #(.NUM_CS(NUM_CS)) u_cs (
    .clk(clk), .rst_n(rst_n), .sel_fire(sel_fire), .sel_nib(op_nib),
    .cs_n(spi_cs_n)
  );

  logic [7:0] st_code;
  assign st_code = state_code(state_q, dir_in_q);

  always_comb begin
    case (host_addr)
      ADDR_PROG: host_rdata = prog_q;
      ADDR_TX:   host_rdata = tx_q;
      ADDR_RX:   host_rdata = rx_q;
      ADDR_LOOP: host_rdata = loop_cfg_q;
      ADDR_CLK:  host_rdata = clk_cfg_q;
      ADDR_STAT: host_rdata = pack_status(rx_full_q, rx_ovr_q, rx_und_q,
                                          tx_full_q, tx_ovr_q, st_code);
      default:   host_rdata = '0;
    endcase
  end

  // R9: a write into a full transmit register flags overrun
  a_r9_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_full_q) |=> tx_ovr_q);
  // R5: receive-full rises only when a shift-in completes
  a_r5_rx_full_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full_q) |-> $past(rx_load));
  // R4: a finished shift-out leaves the transmit register empty
  a_r4_out_empties: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !tx_full_q);
  // R13: state code is always one-hot
  a_r13_code_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_code) == 1);
  // R12: the shifter is busy exactly while the sequencer is shifting
  a_r12_busy_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> state_q == ST_SHIFT);
endmodule

// File: tb/spi_opseq_tb.sv
module spi_opseq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        spi_sck, spi_mosi, spi_miso;
  logic [3:0]  spi_cs_n;

  always #4 clk = ~clk;

  spi_opseq dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // serial slave: MISO pattern advanced on falling SCK
  int cyc = 0, sck_rises = 0, fall_cnt = 0, fall_base = 0, rise_cyc = 0, hi_len = 0;
  logic [63:0] slave_pat = '0;
  always @(posedge clk) cyc++;
  always @(posedge spi_sck) begin sck_rises++; rise_cyc = cyc; end
  always @(negedge spi_sck) begin fall_cnt++; hi_len = cyc - rise_cyc; end
  assign spi_miso = slave_pat[63 - ((fall_cnt - fall_base) % 64)];

  // scoreboard for transmitted bytes
  logic [7:0] exp_q[$];
  bit         mon_en = 0;
  logic [7:0] mbits = '0;
  int         mcount = 0, mon_bytes = 0;
  always @(posedge spi_sck) if (mon_en) begin
    mbits = {mbits[6:0], spi_mosi};
    mcount++;
    if (mcount == 8) begin
      logic [7:0] e;
      mcount = 0;
      mon_bytes++;
      if (exp_q.size() == 0) chk(0, "R4", "unexpected byte", {56'd0, mbits}, 64'd0);
      else begin
        e = exp_q.pop_front();
        chk(mbits == e, "R4", "mosi byte", {56'd0, mbits}, {56'd0, e});
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk); host_addr = a; host_re = 1'b1;
    #1 d = host_rdata;
    @(negedge clk); host_re = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    logic [63:0] s;
    int n = 0;
    do begin rd(3'd5, s); n++; end while (s[55:48] != 8'h01 && n < 3000);
    chk(s[55:48] == 8'h01, req, "return to idle", {56'd0, s[55:48]}, 64'h01);
  endtask

  task automatic wait_tx_empty(input string req);
    logic [63:0] s;
    int n = 0;
    do begin rd(3'd5, s); n++; end while (s[59] && n < 1000);
    chk(!s[59], req, "transmit drained", {63'd0, s[59]}, 64'd0);
  endtask

  // run a shift-out program, refilling the transmit register per byte
  task automatic run_tx(input string req, input logic [63:0] prog,
                        input logic [7:0] b [8], input int n);
    int start = mon_bytes;
    for (int i = 0; i < n; i++) exp_q.push_back(b[i]);
    mon_en = 1;
    wr(3'd1, {b[0], 56'd0});
    wr(3'd0, prog);
    for (int i = 1; i < n; i++) begin
      wait_tx_empty(req);
      wr(3'd1, {b[i], 56'd0});
    end
    wait_idle(req);
    mon_en = 0;
    chk(mon_bytes - start == n, req, "byte count", 64'(mon_bytes - start), 64'(n));
    chk(exp_q.size() == 0, req, "scoreboard drained", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [7:0] bb [8];
    int r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd5, v);
    chk(v == 64'h0001_0000_0000_0000, "R1", "status after reset", v, 64'h0001_0000_0000_0000);
    chk(spi_cs_n == 4'hF && spi_sck == 1'b0, "R1", "pins after reset",
        {59'd0, spi_sck, spi_cs_n}, 64'h0F);
    rd(3'd4, v);
    chk(v == {12'd19, 52'd0}, "R1", "clock cfg reset", v, {12'd19, 52'd0});
    wr(3'd4, {12'd1, 52'd0});

    // R2 / R3 order and last slot
    wr(3'd0, {8'h12, 8'h11, 8'h00, 40'd0});
    wait_idle("R2");
    chk(spi_cs_n == 4'b1110, "R2", "slot order, last select wins", {60'd0, spi_cs_n}, 64'hE);
    wr(3'd0, {{7{8'h10}}, 8'h13});
    wait_idle("R2");
    chk(spi_cs_n == 4'b1011, "R2", "slot 7 executed", {60'd0, spi_cs_n}, 64'hB);
    wr(3'd0, {8'h10, 56'd0});
    wait_idle("R3");
    chk(spi_cs_n == 4'hF, "R3", "select 0 releases all", {60'd0, spi_cs_n}, 64'hF);

    // R4 shift out two bytes, R13 state code while shifting out
    exp_q.push_back(8'hA5); exp_q.push_back(8'h5A);
    mon_en = 1; r0 = mon_bytes;
    wr(3'd1, 64'hA55A_0000_0000_0000);
    wr(3'd0, {8'h11, 8'h32, 8'h10, 40'd0});
    repeat (6) @(negedge clk);
    rd(3'd5, v);
    chk(v[55:48] == 8'h04, "R13", "state shifting out", {56'd0, v[55:48]}, 64'h04);
    chk(spi_cs_n == 4'b1110, "R3", "cs0 low during shift", {60'd0, spi_cs_n}, 64'hE);
    wait_idle("R4");
    mon_en = 0;
    chk(mon_bytes - r0 == 2, "R4", "two bytes sent", 64'(mon_bytes - r0), 64'd2);
    rd(3'd5, v);
    chk(!v[59], "R4", "transmit-full cleared", {63'd0, v[59]}, 64'd0);

    // R5 shift in three bytes to low-order bytes
    slave_pat = 64'hC37E_1900_0000_0000; fall_base = fall_cnt;
    wr(3'd0, {8'h12, 8'h43, 8'h10, 40'd0});
    wait_idle("R5");
    rd(3'd5, v);
    chk(v[63], "R5", "receive-full set", {63'd0, v[63]}, 64'd1);
    rd(3'd2, v);
    chk(v == 64'h0000_0000_00C3_7E19, "R5", "received word", v, 64'h00C37E19);
    rd(3'd5, v);
    chk(!v[63], "R5", "read clears full", {63'd0, v[63]}, 64'd0);

    // R6 counted branch: count 2 gives three passes
    wr(3'd3, 64'd2 << 32);
    bb = '{8'h81, 8'h42, 8'h24, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    run_tx("R6", {8'h11, 8'h31, 8'hE1, 8'h10, 32'd0}, bb, 3);
    // R6 reload: count 1 with reload over two loops gives four bytes
    wr(3'd3, (64'd1 << 32) | (64'd1 << 11));
    bb = '{8'hF0, 8'h0F, 8'hCC, 8'h33, 8'h00, 8'h00, 8'h00, 8'h00};
    run_tx("R6", {8'h11, 8'h31, 8'hE1, 8'h31, 8'hE3, 8'h10, 16'd0}, bb, 4);
    wr(3'd3, 64'd0);

    // R9 overrun, R11 clear
    wr(3'd1, 64'h1111_0000_0000_0000);
    wr(3'd1, 64'h2222_0000_0000_0000);
    rd(3'd5, v);
    chk(v[58] && v[59], "R9", "overrun and full", {62'd0, v[59], v[58]}, 64'd3);
    rd(3'd1, v);
    chk(v == 64'h1111_0000_0000_0000, "R9", "second write discarded", v, 64'h1111_0000_0000_0000);
    wr(3'd5, 64'd0);
    rd(3'd5, v);
    chk(!v[58], "R11", "zero write clears overrun", {63'd0, v[58]}, 64'd0);
    wr(3'd0, {8'h31, 56'd0});
    wait_idle("R4");

    // R10 underrun and overrun, R11 selective clear
    rd(3'd2, v);
    wr(3'd2, 64'd5);
    rd(3'd5, v);
    chk(v[62:61] == 2'b11, "R10", "rx under/overrun flags", {62'd0, v[62:61]}, 64'd3);
    wr(3'd5, 64'd1 << 62);
    rd(3'd5, v);
    chk(v[62:61] == 2'b10, "R11", "selective clear", {62'd0, v[62:61]}, 64'd2);
    wr(3'd5, 64'd0);

    // R8 copy receive to transmit
    slave_pat = 64'h5A00_0000_0000_0000; fall_base = fall_cnt;
    wr(3'd0, {8'h41, 8'hC0, 48'd0});
    wait_idle("R8");
    rd(3'd5, v);
    chk(v[63] == 1'b0 && v[59] == 1'b1, "R8", "flags after copy", {62'd0, v[63], v[59]}, 64'd1);
    rd(3'd1, v);
    chk(v == 64'h5A, "R8", "copied word", v, 64'h5A);
    wr(3'd0, {8'h31, 56'd0});
    wait_idle("R8");

    // R7 implicit mode waits for one transmit write
    wr(3'd3, 64'd1 << 10);
    slave_pat = 64'h9900_0000_0000_0000; fall_base = fall_cnt;
    r0 = sck_rises;
    wr(3'd0, {8'h41, 56'd0});
    repeat (40) @(negedge clk);
    rd(3'd5, v);
    chk(v[55:48] == 8'h02 && sck_rises == r0, "R7", "waits before clocking",
        {56'd0, v[55:48]}, 64'h02);
    wr(3'd1, 64'd0);
    wait_idle("R7");
    rd(3'd5, v);
    chk(v[63] && !v[59], "R7", "consumed write, received", {62'd0, v[63], v[59]}, 64'd2);
    rd(3'd2, v);
    chk(v == 64'h99, "R7", "received byte", v, 64'h99);
    wr(3'd3, 64'd0);

    // R5 stall while full, R2 program write ignored while running
    slave_pat = 64'h3C96_0000_0000_0000; fall_base = fall_cnt;
    wr(3'd0, {8'h41, 56'd0});
    wait_idle("R5");
    r0 = sck_rises;
    wr(3'd0, {8'h41, 56'd0});
    repeat (40) @(negedge clk);
    rd(3'd5, v);
    chk(v[55:48] == 8'h02 && sck_rises == r0, "R5", "stall while full",
        {56'd0, v[55:48]}, 64'h02);
    wr(3'd0, 64'd0);
    rd(3'd2, v);
    chk(v == 64'h3C, "R5", "first byte", v, 64'h3C);
    wait_idle("R2");
    rd(3'd5, v);
    chk(v[63], "R2", "busy write ignored, run completed", {63'd0, v[63]}, 64'd1);
    rd(3'd2, v);
    chk(v == 64'h96, "R5", "second byte", v, 64'h96);

    // R12 divider 3, R13 shifting-in code
    wr(3'd4, {12'd3, 52'd0});
    wr(3'd0, {8'h41, 56'd0});
    repeat (20) @(negedge clk);
    rd(3'd5, v);
    chk(v[55:48] == 8'h08, "R13", "state shifting in", {56'd0, v[55:48]}, 64'h08);
    wait_idle("R12");
    chk(hi_len == 4, "R12", "SCK high time", 64'(hi_len), 64'd4);
    rd(3'd2, v);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule